// File: doc/BRIEF.md
# SPI Command Slave for a Sensor Front End

This block is the serial control port of a sensor front end. An external controller selects the slave by pulling an active-low chip select. It then clocks in an 8-bit command on MOSI. The slave decodes the command and takes one of these actions:

- return one of two 11-bit acceleration words or a temperature byte on MISO;
- accept a write of the temperature byte;
- issue a one-cycle mode strobe for measure mode, X self-test or Y self-test;
- load a lock register.

Codes outside the public set are honoured only while the lock register holds a key value. While the lock is open, such a code is reported as a test-command strobe that carries the code.

The serial pins are synchronised into the system clock, and all internal work runs in that clock domain. The system clock must be at least 8 times the SCK rate. The parallel read ports are sampled once at the start of each selection. A value that changes during the transfer therefore does not corrupt the word being shifted out. MISO comes with an output enable, so that the pad can float whenever the slave does not drive it.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, `spi_miso_oe` and `spi_miso` are 0 and every strobe output is 0.
- R2: A rising edge of chip select ends the transfer. `spi_miso_oe` drops and the bit count and command are cleared. A transfer cut short before its command or before its first data byte completes has no effect, and the next selection starts cleanly.
- R3: `spi_miso_oe` stays 0 while the 8 command bits arrive. Bits are sampled on rising SCK, MSB first.
- R4: Command 0x10 returns the X word sampled at selection, 11 bits MSB first. The first bit is driven on the SCK falling edge right after the rising edge that sampled the 8th command bit. For example, 975 appears as 01111001111.
- R5: Command 0x11 returns the Y word in the same 11-bit MSB-first format.
- R6: Command 0x08 shifts out the temperature byte MSB first. At the same time it shifts in one write byte. After the 8th data bit, `temp_wr_stb` pulses for one cycle with that byte on `temp_wr_data`. Later data bytes are ignored.
- R7: After the last data bit of a read, MISO is driven low with `spi_miso_oe` high until chip select rises.
- R8: Commands 0x00, 0x0E and 0x0F each give one single-cycle pulse on `meas_stb`, `selftest_x_stb` or `selftest_y_stb` respectively. MISO stays high impedance for the rest of the transfer.
- R9: An unrecognised command (for example 0x33 with the lock closed) gives no strobe and no write, and MISO stays high impedance. Any further bits in that selection are ignored.
- R10: The command LOCK_CMD (default 0x20), followed by a byte, loads that byte into the lock register, which resets to 0. Any non-public code other than LOCK_CMD behaves as R9 unless the lock equals LOCK_KEY (default 0xC3). In that case it pulses `test_cmd_stb` with the code on `test_cmd_code`.
- R11: Read data is taken from the parallel ports at the chip-select falling edge. Changes on those ports later in the selection do not alter the word shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the slave |
| spi_miso | output | 1 | Serial data out of the slave |
| spi_miso_oe | output | 1 | Drive enable for MISO (0 = high impedance) |
| acc_x_in | input | ACC_W | X acceleration word |
| acc_y_in | input | ACC_W | Y acceleration word |
| temp_in | input | 8 | Temperature byte read port |
| meas_stb | output | 1 | Measure-mode command pulse |
| selftest_x_stb | output | 1 | X self-test command pulse |
| selftest_y_stb | output | 1 | Y self-test command pulse |
| temp_wr_stb | output | 1 | Temperature write pulse |
| temp_wr_data | output | 8 | Temperature write byte |
| test_cmd_stb | output | 1 | Accepted hidden command pulse |
| test_cmd_code | output | 8 | Code of the accepted hidden command |

## Verification
The hardest state to reach from the pins is an accepted hidden command. It needs one complete selection that carries the lock command and the key byte, and then a second selection that carries a non-public code. The stimulus therefore sends the hidden code once while the lock is closed and once after unlocking. It then relocks and sends the code a third time, so both sides of the gate are seen. The snapshot rule is reached by changing the X port just after chip select falls and before the command completes. Aborted frames are made by raising chip select after half a command, and again after half a write byte.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
  localparam int CMD_W  = 8;
  localparam int DATA_W = 8;

  localparam logic [CMD_W-1:0] CMD_MEAS = 8'h00;
  localparam logic [CMD_W-1:0] CMD_TEMP = 8'h08;
  localparam logic [CMD_W-1:0] CMD_STX  = 8'h0E;
  localparam logic [CMD_W-1:0] CMD_STY  = 8'h0F;
  localparam logic [CMD_W-1:0] CMD_RDX  = 8'h10;
  localparam logic [CMD_W-1:0] CMD_RDY  = 8'h11;

  typedef enum logic [3:0] {
    K_NONE, K_MEAS, K_STX, K_STY, K_RDX, K_RDY, K_TEMP, K_LOCK, K_TEST, K_BAD
  } cmd_kind_t;

  typedef enum logic [1:0] {
    S_IDLE, S_CMD, S_DATA, S_MUTE
  } xfer_state_t;
endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk) begin
      if (rst) pipe_q <= {STAGES{RST_VAL[g]}};
      else     pipe_q <= {pipe_q[STAGES-2:0], din[g]};
    end
    assign dout[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/spi_edge.sv
`timescale 1ns/1ps
module spi_edge #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;
  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= lvl;
  end
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/spi_rx_shift.sv
`timescale 1ns/1ps
module spi_rx_shift #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  logic              din,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val,
  output logic [CNT_W-1:0]  byte_idx
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] BW      = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] sh_nxt;

  assign sh_nxt = {sh_q[BYTE_W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      byte_stb <= 1'b0;
      byte_val <= '0;
      byte_idx <= '0;
    end else begin
      byte_stb <= 1'b0;
      if (step && cnt_q != CNT_MAX) begin
        sh_q  <= sh_nxt;
        cnt_q <= cnt_q + 1'b1;
        if ((cnt_q % BW) == LAST) begin
          byte_stb <= 1'b1;
          byte_val <= sh_nxt;
          byte_idx <= cnt_q / BW;
        end
      end
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt_q == '0 && !byte_stb)); // R2
endmodule

// File: rtl/spi_cmd_decode.sv
`timescale 1ns/1ps
module spi_cmd_decode import spi_cmd_pkg::*; #(
  parameter logic [CMD_W-1:0] LOCK_CMD = 8'h20,
  parameter logic [CMD_W-1:0] LOCK_KEY = 8'hC3
) (
  input  logic [CMD_W-1:0] code,
  input  logic [CMD_W-1:0] lock_val,
  output cmd_kind_t        kind
);
  always_comb begin
    case (code)
      CMD_MEAS: kind = K_MEAS;
      CMD_TEMP: kind = K_TEMP;
      CMD_STX:  kind = K_STX;
      CMD_STY:  kind = K_STY;
      CMD_RDX:  kind = K_RDX;
      CMD_RDY:  kind = K_RDY;
      default: begin
        if (code == LOCK_CMD)          kind = K_LOCK;
        else if (lock_val == LOCK_KEY) kind = K_TEST;
        else                           kind = K_BAD;
      end
    endcase
  end
endmodule

// File: rtl/spi_tx_shift.sv
`timescale 1ns/1ps
module spi_tx_shift #(
  parameter int W     = 11,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [W-1:0]     load_word,
  input  logic [LEN_W-1:0] load_len,
  input  logic             shift,
  output logic             miso,
  output logic             oe
);
  logic [W-1:0]     sh_q;
  logic [LEN_W-1:0] left_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh_q    <= '0;
      left_q  <= '0;
      armed_q <= 1'b0;
      miso    <= 1'b0;
      oe      <= 1'b0;
    end else if (load) begin
      sh_q    <= load_word;
      left_q  <= load_len;
      armed_q <= 1'b1;
    end else if (shift && armed_q) begin
      oe <= 1'b1;
      if (left_q != '0) begin
        miso   <= sh_q[W-1];
        sh_q   <= {sh_q[W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end else begin
        miso <= 1'b0;
      end
    end
  end

  AST_TAIL_LOW: assert property (@(posedge clk) disable iff (rst)
    (shift && armed_q && !load && !clear && left_q == '0) |=> (oe && !miso)); // R7
  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(shift)); // R4
endmodule

// File: rtl/spi_cmd_slave.sv
`timescale 1ns/1ps
module spi_cmd_slave import spi_cmd_pkg::*; #(
  parameter int               ACC_W       = 11,
  parameter int               SYNC_STAGES = 2,
  parameter int               BIT_CNT_W   = 5,
  parameter logic [CMD_W-1:0] LOCK_CMD    = 8'h20,
  parameter logic [CMD_W-1:0] LOCK_KEY    = 8'hC3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [ACC_W-1:0]  acc_x_in,
  input  logic [ACC_W-1:0]  acc_y_in,
  input  logic [DATA_W-1:0] temp_in,
  output logic              meas_stb,
  output logic              selftest_x_stb,
  output logic              selftest_y_stb,
  output logic              temp_wr_stb,
  output logic [DATA_W-1:0] temp_wr_data,
  output logic              test_cmd_stb,
  output logic [CMD_W-1:0]  test_cmd_code
);
  localparam int LEN_W = $clog2(ACC_W + 1);
  localparam logic [BIT_CNT_W-1:0] IDX_FIRST_DATA = BIT_CNT_W'(1);

  logic [2:0] pins_s;
  logic [1:0] edge_r, edge_f;
  logic       sck_rise, sck_fall, cs_fall, cs_rise, mosi_s;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .din({spi_mosi, spi_csn, spi_sck}), .dout(pins_s));

  spi_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst(rst), .lvl(pins_s[1:0]), .rise(edge_r), .fall(edge_f));

  assign sck_rise = edge_r[0];
  assign sck_fall = edge_f[0];
  assign cs_rise  = edge_r[1];
  assign cs_fall  = edge_f[1];
  assign mosi_s   = pins_s[2];

  xfer_state_t          state_q;
  cmd_kind_t            kind_q, dec_kind;
  logic [CMD_W-1:0]     lock_q;
  logic [ACC_W-1:0]     snap_x, snap_y;
  logic [DATA_W-1:0]    snap_t;

  logic                 rx_stb;
  logic [CMD_W-1:0]     rx_byte;
  logic [BIT_CNT_W-1:0] rx_idx;
  logic                 rx_step, frame_clr;

  assign frame_clr = cs_rise | cs_fall;
  assign rx_step   = sck_rise && (state_q == S_CMD || state_q == S_DATA);

  spi_rx_shift #(.BYTE_W(CMD_W), .CNT_W(BIT_CNT_W)) u_rx (
    .clk(clk), .rst(rst), .clear(frame_clr), .step(rx_step), .din(mosi_s),
    .byte_stb(rx_stb), .byte_val(rx_byte), .byte_idx(rx_idx));

  spi_cmd_decode #(.LOCK_CMD(LOCK_CMD), .LOCK_KEY(LOCK_KEY)) u_dec (
    .code(rx_byte), .lock_val(lock_q), .kind(dec_kind));

  logic             tx_load;
  logic [ACC_W-1:0] tx_word;
  logic [LEN_W-1:0] tx_len;
  logic             cmd_done;

  assign cmd_done = rx_stb && state_q == S_CMD && !frame_clr;

  always_comb begin
    tx_load = 1'b0;
    tx_word = '0;
    tx_len  = '0;
    if (cmd_done) begin
      case (dec_kind)
        K_RDX: begin
          tx_load = 1'b1;
          tx_word = snap_x;
          tx_len  = LEN_W'(ACC_W);
        end
        K_RDY: begin
          tx_load = 1'b1;
          tx_word = snap_y;
          tx_len  = LEN_W'(ACC_W);
        end
        K_TEMP: begin
          tx_load = 1'b1;
          tx_word = ACC_W'(snap_t) << (ACC_W - DATA_W);
          tx_len  = LEN_W'(DATA_W);
        end
        default: tx_load = 1'b0;
      endcase
    end
  end

  spi_tx_shift #(.W(ACC_W), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst(rst), .clear(frame_clr), .load(tx_load),
    .load_word(tx_word), .load_len(tx_len), .shift(sck_fall),
    .miso(spi_miso), .oe(spi_miso_oe));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= S_IDLE;
      kind_q         <= K_NONE;
      lock_q         <= '0;
      snap_x         <= '0;
      snap_y         <= '0;
      snap_t         <= '0;
      meas_stb       <= 1'b0;
      selftest_x_stb <= 1'b0;
      selftest_y_stb <= 1'b0;
      temp_wr_stb    <= 1'b0;
      temp_wr_data   <= '0;
      test_cmd_stb   <= 1'b0;
      test_cmd_code  <= '0;
    end else begin
      meas_stb       <= 1'b0;
      selftest_x_stb <= 1'b0;
      selftest_y_stb <= 1'b0;
      temp_wr_stb    <= 1'b0;
      test_cmd_stb   <= 1'b0;
      if (cs_rise) begin
        state_q <= S_IDLE;
        kind_q  <= K_NONE;
      end else if (cs_fall) begin
        state_q <= S_CMD;
        kind_q  <= K_NONE;
        snap_x  <= acc_x_in;
        snap_y  <= acc_y_in;
        snap_t  <= temp_in;
      end else if (rx_stb) begin
        if (state_q == S_CMD) begin
          kind_q <= dec_kind;
          case (dec_kind)
            K_MEAS: begin
              meas_stb <= 1'b1;
              state_q  <= S_MUTE;
            end
            K_STX: begin
              selftest_x_stb <= 1'b1;
              state_q        <= S_MUTE;
            end
            K_STY: begin
              selftest_y_stb <= 1'b1;
              state_q        <= S_MUTE;
            end
            K_RDX, K_RDY, K_TEMP, K_LOCK: state_q <= S_DATA;
            K_TEST: begin
              test_cmd_stb  <= 1'b1;
              test_cmd_code <= rx_byte;
              state_q       <= S_MUTE;
            end
            default: state_q <= S_MUTE;
          endcase
        end else if (state_q == S_DATA && rx_idx == IDX_FIRST_DATA) begin
          if (kind_q == K_TEMP) begin
            temp_wr_stb  <= 1'b1;
            temp_wr_data <= rx_byte;
          end else if (kind_q == K_LOCK) begin
            lock_q <= rx_byte;
          end
        end
      end
    end
  end

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> !spi_miso_oe); // R2
  AST_CMD_HIZ: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_CMD) |-> !spi_miso_oe); // R3
  AST_MUTE_HIZ: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_MUTE) |-> !spi_miso_oe); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({meas_stb, selftest_x_stb, selftest_y_stb, temp_wr_stb, test_cmd_stb})); // R8
  AST_WR_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    temp_wr_stb |-> $past(state_q == S_DATA)); // R6
  AST_TEST_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    test_cmd_stb |-> (lock_q == LOCK_KEY)); // R10
endmodule

// File: tb/spi_cmd_slave_tb.sv
`timescale 1ns/1ps
module spi_cmd_slave_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic        miso, oe;
  logic [10:0] acc_x = '0, acc_y = '0;
  logic [7:0]  temp = '0;
  logic        meas_stb, stx_stb, sty_stb, twr_stb, tst_stb;
  logic [7:0]  twr_data, tst_code;

  int compared = 0;
  int mismatched = 0;
  logic [11:0] exp_q[$];
  bit          chg_en = 1'b0;
  logic [10:0] chg_val = '0;

  spi_cmd_slave dut_i (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(oe), .acc_x_in(acc_x), .acc_y_in(acc_y),
    .temp_in(temp), .meas_stb(meas_stb), .selftest_x_stb(stx_stb),
    .selftest_y_stb(sty_stb), .temp_wr_stb(twr_stb), .temp_wr_data(twr_data),
    .test_cmd_stb(tst_stb), .test_cmd_code(tst_code));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic string req_of(input logic [3:0] k);
    if (k == 4'd4) return "R6";
    if (k == 4'd5) return "R10";
    return "R8";
  endfunction

  // Monitor: each strobe seen is compared with the oldest expected item
  task automatic mon_ev(input logic [11:0] got);
    logic [11:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, req_of(got[11:8]), "unexpected strobe", int'(got), 0);
    end else begin
      e = exp_q.pop_front();
      chk(got == e, req_of(e[11:8]), "strobe item", int'(got), int'(e));
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (meas_stb) mon_ev({4'd1, 8'h00});
      if (stx_stb)  mon_ev({4'd2, 8'h00});
      if (sty_stb)  mon_ev({4'd3, 8'h00});
      if (twr_stb)  mon_ev({4'd4, twr_data});
      if (tst_stb)  mon_ev({4'd5, tst_code});
    end
  end

  // Driver: ncb command bits, then nd data bits; nout expected output bits
  task automatic xfer(input logic [7:0] cmd, input int ncb, input int nd,
                      input logic [23:0] din, input int nout,
                      input logic [15:0] dexp, input string req);
    csn = 1'b0;
    repeat (8) @(negedge clk);
    if (chg_en) begin
      acc_x  = chg_val;
      chg_en = 1'b0;
    end
    for (int i = 0; i < ncb + nd; i++) begin
      if (i < ncb) mosi = cmd[7-i];
      else         mosi = din[nd-1-(i-ncb)];
      repeat (8) @(negedge clk);
      if (i < 8) begin
        chk(oe === 1'b0, "R3", "oe during command", int'(oe), 0);
      end else if (i - 8 < nout) begin
        chk(oe === 1'b1 && miso === dexp[nout-1-(i-8)], req, "data bit",
            int'({oe, miso}), int'({1'b1, dexp[nout-1-(i-8)]}));
      end else if (nout > 0) begin
        chk(oe === 1'b1 && miso === 1'b0, "R7", "tail low",
            int'({oe, miso}), 2);
      end else begin
        chk(oe === 1'b0, req, "no drive", int'(oe), 0);
      end
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
    repeat (8) @(negedge clk);
    csn  = 1'b1;
    mosi = 1'b0;
    repeat (8) @(negedge clk);
    chk(oe === 1'b0, "R2", "oe after deselect", int'(oe), 0);
    repeat (16) @(negedge clk);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(oe === 1'b0 && miso === 1'b0, "R1", "miso/oe after reset",
        int'({oe, miso}), 0);
    chk({meas_stb, stx_stb, sty_stb, twr_stb, tst_stb} === 5'b0, "R1",
        "strobes after reset",
        int'({meas_stb, stx_stb, sty_stb, twr_stb, tst_stb}), 0);

    // R4 read X = 975, three tail clocks (R7)
    acc_x = 11'd975;
    xfer(8'h10, 8, 14, 24'h0, 11, 16'(11'd975), "R4");
    // R5 read Y
    acc_y = 11'h5A3;
    xfer(8'h11, 8, 11, 24'h0, 11, 16'(11'h5A3), "R5");
    // R6 temperature read with write, second byte ignored
    temp = 8'hB6;
    exp_q.push_back({4'd4, 8'h3C});
    xfer(8'h08, 8, 16, 24'h3CFF, 8, 16'h00B6, "R6");
    // R8 mode strobes, trailing bits leave MISO floating
    exp_q.push_back({4'd1, 8'h00});
    xfer(8'h00, 8, 0, 24'h0, 0, 16'h0, "R8");
    exp_q.push_back({4'd2, 8'h00});
    xfer(8'h0E, 8, 8, 24'hFF, 0, 16'h0, "R8");
    exp_q.push_back({4'd3, 8'h00});
    xfer(8'h0F, 8, 0, 24'h0, 0, 16'h0, "R8");
    // R9 invalid command with trailing data, then a normal read
    xfer(8'h33, 8, 16, 24'h08A5, 0, 16'h0, "R9");
    acc_x = 11'h401;
    xfer(8'h10, 8, 11, 24'h0, 11, 16'(11'h401), "R9");
    // R10 hidden code while locked, unlock, accepted, relock, rejected
    xfer(8'h77, 8, 8, 24'h0, 0, 16'h0, "R10");
    xfer(8'h20, 8, 8, 24'hC3, 0, 16'h0, "R10");
    exp_q.push_back({4'd5, 8'h77});
    xfer(8'h77, 8, 0, 24'h0, 0, 16'h0, "R10");
    xfer(8'h20, 8, 8, 24'h00, 0, 16'h0, "R10");
    xfer(8'h77, 8, 0, 24'h0, 0, 16'h0, "R10");
    // R2 aborted command, aborted write, then clean read
    xfer(8'h10, 4, 0, 24'h0, 0, 16'h0, "R2");
    xfer(8'h08, 8, 4, 24'h5, 8, 16'h00B6, "R2");
    acc_y = 11'h0F0;
    xfer(8'h11, 8, 11, 24'h0, 11, 16'(11'h0F0), "R2");
    // R11 snapshot at selection
    acc_x   = 11'h2AB;
    chg_val = 11'h154;
    chg_en  = 1'b1;
    xfer(8'h10, 8, 11, 24'h0, 11, 16'(11'h2AB), "R11");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R6 R8 R10", "missing strobes", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule